// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models a small parallel NOR flash device on a plain synchronous bus. It decodes a sequence of bus writes into flash operations: programming a single word, erasing a whole sector after a confirm write, a counted buffered write of several words, status viewing and clearing, a lock/unlock handshake that is acknowledged but not enforced, and a query mode that returns a small identification ROM. A write of the read-array code always brings the device back to normal reads.

What a bus write means depends on two pieces of state: the command that is pending and the cycle index within that command. The read path returns one of three sources, chosen by the pending command: array words, the 8-bit status byte (zero-extended), or a query ROM byte (zero-extended). Read data is registered and appears one cycle after the read strobe. Program and erase complete at once, so status bit 7 (ready) is set as soon as an operation finishes.

Top module: `nor_flash_cmd_if`

## Requirements
- R1: After reset the status byte is 0x00, no command is pending, rdata is 0 and every array word reads as all ones; a write that would have been program data for a sequence interrupted by reset is decoded as a fresh command instead.
- R2: From idle, a write with low byte 0x10 or 0x40 arms a program; the next write stores its full data word at its address, sets status bit 7 and returns to read-array mode.
- R3: A write of 0x20 followed by 0xD0 fills every word of the sector that holds the first write's address with all ones, leaves other sectors intact and sets status bit 7; nothing is erased before the 0xD0 arrives.
- R4: In a pending erase or lock sequence, a second write of 0xFF abandons it and returns to read-array mode; in an erase sequence any value other than 0xD0 also returns to read-array mode without erasing.
- R5: 0xE8 starts a buffered write and sets status bit 7; the next write gives a count N (low 8 bits), the next N+1 writes store data words at their addresses, and a final 0xD0 completes it; any other final value returns to read-array mode, keeping the words already stored.
- R6: 0x70 selects status view; 0x50 clears the status byte to 0x00 and returns to read-array mode.
- R7: 0x60 starts a lock sequence; a second write of 0xD0 or 0x01 sets status bit 7 and ends the sequence with status view active; any other value returns to read-array mode.
- R8: While the pending command is erase, lock, status view or buffered write, reads return the status byte in bits 7:0 with upper bits zero.
- R9: 0x98 enters query mode; reads return the ROM byte at index address>>log2(bytes per word): 0x51, 0x52, 0x59 at 0x10..0x12, log2 of array bytes at 0x27, sector count minus one at 0x2D; indices of 0x31 and above read 0; writes other than 0xFF keep query mode, and 0xFF leaves it.
- R10: In idle, a write of 0x00 or of any code not listed above, including one given while status view is active, returns the device to read-array mode.
- R11: rdata changes only on the clock edge that samples the read strobe and holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data; bits 7:0 carry command codes |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after bus_re |

## Verification
The bench builds the block with 16-bit words, four sectors of sixteen words and an 8-bit buffered-write count, giving a 128-byte array whose 7-bit address reaches every query ROM index up to 0x3F. The whole array and the past-end query region are therefore within reach, and a word in a neighbouring sector shows that an erase stays inside its own sector. Two-byte words make the query index differ from the byte address, so a wrong shift shows up as a wrong ROM byte.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [2:0] {
    PC_NONE,
    PC_PROG,
    PC_ERASE,
    PC_LOCK,
    PC_STATUS,
    PC_BUFW,
    PC_QUERY
  } pend_t;

  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUFW    = 8'hE8;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_UNLOCK  = 8'h01;

  localparam int QUERY_LEN = 49;

  function automatic logic first_known(input logic [7:0] b);
    return (b == OP_PROG_A) || (b == OP_PROG_B) || (b == OP_ERASE) ||
           (b == OP_CLEAR)  || (b == OP_LOCK)   || (b == OP_STATUS) ||
           (b == OP_QUERY)  || (b == OP_BUFW);
  endfunction

  function automatic logic shows_status(input pend_t p);
    return (p == PC_ERASE) || (p == PC_LOCK) || (p == PC_STATUS) || (p == PC_BUFW);
  endfunction

  function automatic logic [7:0] query_entry(input int idx, input int dev_log2,
                                             input int sectors, input int sect_bytes,
                                             input int buf_log2);
    logic [7:0] v;
    int sm1;
    sm1 = sectors - 1;
    case (idx)
      16'h10: v = 8'h51;
      16'h11: v = 8'h52;
      16'h12: v = 8'h59;
      16'h13: v = 8'h01;
      16'h1B: v = 8'h45;
      16'h1C: v = 8'h55;
      16'h27: v = 8'(dev_log2);
      16'h28: v = 8'h02;
      16'h2A: v = 8'(buf_log2);
      16'h2C: v = 8'h01;
      16'h2D: v = 8'(sm1);
      16'h2E: v = 8'(sm1 >> 8);
      16'h2F: v = 8'(sect_bytes >> 8);
      16'h30: v = 8'(sect_bytes >> 16);
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_flash_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WA_W      = 6,
  parameter int SEC_W     = 2,
  parameter int SW_W      = 4,
  parameter int BUF_CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  output pend_t             pend,
  output logic [1:0]        wc,
  output logic [7:0]        status,
  output logic              arr_we,
  output logic              erase_en,
  output logic [SEC_W-1:0]  erase_sec,
  output logic              ev_prog,
  output logic              ev_erase,
  output logic              ev_bword,
  output logic              ev_abort
);

  logic [7:0]           cb;
  pend_t                pend_n;
  logic [1:0]           wc_n;
  logic [7:0]           st_n;
  logic [BUF_CNT_W-1:0] cnt, cnt_n;
  logic [SEC_W-1:0]     sec_n;
  logic                 go_idle;

  assign cb = wdata[7:0];

  always_comb begin
    pend_n   = pend;
    wc_n     = wc;
    st_n     = status;
    cnt_n    = cnt;
    sec_n    = erase_sec;
    go_idle  = 1'b0;
    ev_prog  = 1'b0;
    ev_erase = 1'b0;
    ev_bword = 1'b0;
    if (wr_en) begin
      case (wc)
        2'd0: begin
          case (cb)
            OP_PROG_A, OP_PROG_B: begin pend_n = PC_PROG; wc_n = 2'd1; end
            OP_ERASE: begin
              pend_n = PC_ERASE;
              wc_n   = 2'd1;
              sec_n  = waddr[WA_W-1:SW_W];
            end
            OP_CLEAR: begin st_n = 8'h00; go_idle = 1'b1; end
            OP_LOCK:  begin pend_n = PC_LOCK; wc_n = 2'd1; end
            OP_STATUS: pend_n = PC_STATUS;
            OP_QUERY: begin pend_n = PC_QUERY; wc_n = 2'd1; end
            OP_BUFW: begin
              pend_n  = PC_BUFW;
              wc_n    = 2'd1;
              st_n[7] = 1'b1;
            end
            default: go_idle = 1'b1;
          endcase
        end
        2'd1: begin
          case (pend)
            PC_PROG: begin
              ev_prog = 1'b1;
              st_n[7] = 1'b1;
              go_idle = 1'b1;
            end
            PC_ERASE: begin
              if (cb == OP_CONFIRM) begin
                ev_erase = 1'b1;
                st_n[7]  = 1'b1;
                wc_n     = 2'd0;
              end else begin
                go_idle = 1'b1;
              end
            end
            PC_LOCK: begin
              if (cb == OP_CONFIRM || cb == OP_UNLOCK) begin
                st_n[7] = 1'b1;
                wc_n    = 2'd0;
              end else begin
                go_idle = 1'b1;
              end
            end
            PC_BUFW: begin
              cnt_n = wdata[BUF_CNT_W-1:0];
              wc_n  = 2'd2;
            end
            PC_QUERY: begin
              if (cb == OP_ARRAY) go_idle = 1'b1;
            end
            default: go_idle = 1'b1;
          endcase
        end
        2'd2: begin
          if (pend == PC_BUFW) begin
            ev_bword = 1'b1;
            st_n[7]  = 1'b1;
            if (cnt == '0) wc_n = 2'd3;
            cnt_n = cnt - 1'b1;
          end else begin
            go_idle = 1'b1;
          end
        end
        default: begin
          if (pend == PC_BUFW && cb == OP_CONFIRM) begin
            st_n[7] = 1'b1;
            wc_n    = 2'd0;
          end else begin
            go_idle = 1'b1;
          end
        end
      endcase
    end
    if (go_idle) begin
      pend_n = PC_NONE;
      wc_n   = 2'd0;
    end
  end

  assign ev_abort = go_idle;
  assign arr_we   = ev_prog | ev_bword;
  assign erase_en = ev_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= PC_NONE;
      wc        <= 2'd0;
      status    <= 8'h00;
      cnt       <= '0;
      erase_sec <= '0;
    end else begin
      pend      <= pend_n;
      wc        <= wc_n;
      status    <= st_n;
      cnt       <= cnt_n;
      erase_sec <= sec_n;
    end
  end

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
  parameter int DATA_W       = 16,
  parameter int WORDS        = 64,
  parameter int SECTOR_WORDS = 16,
  parameter int WA_W         = 6,
  parameter int SEC_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              erase_en,
  input  logic [SEC_W-1:0]  erase_sec,
  input  logic [WA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rword
);

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(w / SECTOR_WORDS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[w] <= '1;
      end else if (erase_en && erase_sec == MY_SEC) begin
        mem[w] <= '1;
      end else if (we && waddr == WA_W'(w)) begin
        mem[w] <= wdata;
      end
    end
  end

  assign rword = mem[raddr];

endmodule

// File: rtl/nor_query_rom.sv
module nor_query_rom
  import nor_flash_pkg::*;
#(
  parameter int QI_W       = 6,
  parameter int DEV_LOG2   = 7,
  parameter int SECTORS    = 4,
  parameter int SECT_BYTES = 32,
  parameter int BUF_LOG2   = 9
) (
  input  logic [QI_W-1:0] idx,
  output logic [7:0]      qbyte
);

  always_comb begin
    if (int'(idx) < QUERY_LEN)
      qbyte = query_entry(int'(idx), DEV_LOG2, SECTORS, SECT_BYTES, BUF_LOG2);
    else
      qbyte = 8'h00;
  end

endmodule

// File: rtl/nor_flash_cmd_if.sv
module nor_flash_cmd_if
  import nor_flash_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SECTOR_WORDS = 16,
  parameter int SECTORS      = 4,
  parameter int BUF_CNT_W    = 8,
  localparam int BYTES       = DATA_W / 8,
  localparam int BYTE_SH     = $clog2(BYTES),
  localparam int WORDS       = SECTOR_WORDS * SECTORS,
  localparam int WA_W        = $clog2(WORDS),
  localparam int ADDR_W      = WA_W + BYTE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int SW_W     = $clog2(SECTOR_WORDS);
  localparam int SEC_W    = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int QI_W     = ADDR_W - BYTE_SH;
  localparam int DEV_LOG2 = ADDR_W;
  localparam int SECT_B   = SECTOR_WORDS * BYTES;
  localparam int BUF_LOG2 = BUF_CNT_W + BYTE_SH;

  logic [WA_W-1:0]   word_addr;
  pend_t             pend;
  logic [1:0]        wc;
  logic [7:0]        status;
  logic              arr_we, erase_en;
  logic [SEC_W-1:0]  erase_sec;
  logic              ev_prog, ev_erase, ev_bword, ev_abort;
  logic [DATA_W-1:0] arr_word;
  logic [7:0]        qbyte;

  assign word_addr = bus_addr[ADDR_W-1:BYTE_SH];

  nor_cmd_seq #(
    .DATA_W(DATA_W), .WA_W(WA_W), .SEC_W(SEC_W), .SW_W(SW_W), .BUF_CNT_W(BUF_CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .waddr(word_addr), .wdata(bus_wdata),
    .pend(pend), .wc(wc), .status(status), .arr_we(arr_we), .erase_en(erase_en),
    .erase_sec(erase_sec), .ev_prog(ev_prog), .ev_erase(ev_erase),
    .ev_bword(ev_bword), .ev_abort(ev_abort)
  );

  nor_word_array #(
    .DATA_W(DATA_W), .WORDS(WORDS), .SECTOR_WORDS(SECTOR_WORDS),
    .WA_W(WA_W), .SEC_W(SEC_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(word_addr), .wdata(bus_wdata),
    .erase_en(erase_en), .erase_sec(erase_sec), .raddr(word_addr), .rword(arr_word)
  );

  nor_query_rom #(
    .QI_W(QI_W), .DEV_LOG2(DEV_LOG2), .SECTORS(SECTORS),
    .SECT_BYTES(SECT_B), .BUF_LOG2(BUF_LOG2)
  ) u_rom (
    .idx(word_addr), .qbyte(qbyte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (shows_status(pend))
        bus_rdata <= DATA_W'(status);
      else if (pend == PC_QUERY)
        bus_rdata <= DATA_W'(qbyte);
      else
        bus_rdata <= arr_word;
    end
  end

endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int BYTE_SH = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input pend_t             pend,
  input logic [1:0]        wc,
  input logic [7:0]        status,
  input logic              ev_prog,
  input logic              ev_erase,
  input logic              ev_abort
);

  logic [7:0] cb;
  logic       q_oor;
  assign cb    = bus_wdata[7:0];
  assign q_oor = int'(bus_addr >> BYTE_SH) >= QUERY_LEN;

  a_r2_prog_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> status[7] && pend == PC_NONE && wc == 2'd0);

  a_r3_erase_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase |=> status[7] && wc == 2'd0 && pend == PC_ERASE);

  a_r4_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> pend == PC_NONE && wc == 2'd0);

  a_r5_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wc == 2'd3 && cb != OP_CONFIRM) |=> pend == PC_NONE && wc == 2'd0);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wc == 2'd0 && cb == OP_CLEAR) |=> status == 8'h00 && pend == PC_NONE);

  a_r8_status_view: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && shows_status(pend)) |=> bus_rdata == DATA_W'($past(status)));

  a_r9_query_oor: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && pend == PC_QUERY && q_oor) |=> bus_rdata == '0);

  a_r10_bad_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wc == 2'd0 && !first_known(cb)) |=> pend == PC_NONE && wc == 2'd0);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind nor_flash_cmd_if nor_flash_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_SH(BYTE_SH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend), .wc(wc),
  .status(status), .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_abort(ev_abort)
);

// File: tb/tb_nor_flash_cmd_if.sv
module tb_nor_flash_cmd_if;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 59;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_flash_cmd_if #(.DATA_W(16), .SECTOR_WORDS(16), .SECTORS(4), .BUF_CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  // Vector: {is_read, requirement, byte address, write data or expected read data}
  function automatic logic [28:0] vw(input int r, input logic [7:0] a, input logic [15:0] d);
    return {1'b0, 4'(r), a, d};
  endfunction
  function automatic logic [28:0] vr(input int r, input logic [7:0] a, input logic [15:0] d);
    return {1'b1, 4'(r), a, d};
  endfunction

  localparam logic [28:0] VEC [NV] = '{
    vr(1, 8'h00, 16'hFFFF),                          // R1 erased array
    vw(6, 8'h00, 16'h0070), vr(1, 8'h00, 16'h0000),  // R1 status 0 after reset
    vw(2, 8'h04, 16'h0040), vw(2, 8'h04, 16'h1234), vr(2, 8'h04, 16'h1234), // R2
    vw(6, 8'h00, 16'h0070), vr(6, 8'h00, 16'h0080),  // R6 status view
    vw(6, 8'h00, 16'h0050), vr(6, 8'h04, 16'h1234),  // R6 clear back to array
    vw(6, 8'h00, 16'h0070), vr(6, 8'h00, 16'h0000),  // R6 cleared
    vw(2, 8'h26, 16'h0010), vw(2, 8'h26, 16'hABCD), vr(2, 8'h26, 16'hABCD), // R2 0x10
    vw(2, 8'h06, 16'h0040), vw(2, 8'h06, 16'h5678),
    vw(4, 8'h00, 16'h0020), vw(4, 8'h00, 16'h00FF),  // R4 erase abandoned
    vr(3, 8'h04, 16'h1234),                          // R3 no erase before confirm
    vw(3, 8'h02, 16'h0020), vw(3, 8'h02, 16'h00D0),
    vr(8, 8'h00, 16'h0080),                          // R8 status after erase
    vw(3, 8'h00, 16'h00FF),
    vr(3, 8'h04, 16'hFFFF), vr(3, 8'h06, 16'hFFFF), vr(3, 8'h26, 16'hABCD), // R3
    vw(4, 8'h00, 16'h0020), vw(4, 8'h00, 16'h0033), vr(4, 8'h26, 16'hABCD), // R4 error
    vw(5, 8'h40, 16'h00E8), vw(5, 8'h40, 16'h0002),
    vw(5, 8'h40, 16'h1111), vw(5, 8'h42, 16'h2222), vw(5, 8'h44, 16'h3333),
    vw(5, 8'h00, 16'h00D0), vr(8, 8'h00, 16'h0080),  // R8 status during buffered write
    vw(5, 8'h00, 16'h00FF),
    vr(5, 8'h40, 16'h1111), vr(5, 8'h44, 16'h3333), vr(5, 8'h46, 16'hFFFF), // R5 N+1
    vw(5, 8'h48, 16'h00E8), vw(5, 8'h48, 16'h0000), vw(5, 8'h48, 16'h5555),
    vw(5, 8'h00, 16'h0077), vr(5, 8'h48, 16'h5555),  // R5 bad confirm
    vw(7, 8'h00, 16'h0060), vw(7, 8'h00, 16'h0001), vr(7, 8'h00, 16'h0080), // R7
    vw(6, 8'h00, 16'h0050),
    vw(7, 8'h00, 16'h0060), vw(7, 8'h00, 16'h00D0), vr(7, 8'h00, 16'h0080), // R7
    vw(7, 8'h00, 16'h0060), vw(7, 8'h00, 16'h0022), vr(7, 8'h48, 16'h5555), // R7 bad
    vw(4, 8'h00, 16'h0060), vw(4, 8'h00, 16'h00FF), vr(4, 8'h40, 16'h1111)  // R4 lock
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input string tag, input logic [6:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28])
        do_read($sformatf("R%0d vector %0d", VEC[i][27:24], i), VEC[i][22:16], VEC[i][15:0]);
      else
        do_write(VEC[i][22:16], VEC[i][15:0]);
    end

    // R9 query mode
    do_write(7'h00, 16'h0098);
    do_read("R9 Q", 7'h20, 16'h0051);
    do_read("R9 R", 7'h22, 16'h0052);
    do_read("R9 Y", 7'h24, 16'h0059);
    do_read("R9 size log2", 7'h4E, 16'h0007);
    do_read("R9 sectors-1", 7'h5A, 16'h0003);
    do_read("R9 first past end", 7'h62, 16'h0000);
    do_read("R9 far past end", 7'h7E, 16'h0000);
    do_write(7'h00, 16'h0012);
    do_read("R9 stays in query", 7'h20, 16'h0051);
    do_write(7'h00, 16'h00FF);
    do_read("R9 leaves query", 7'h40, 16'h1111);

    // R10 unknown first command and 0x00
    do_write(7'h00, 16'h0070);
    do_write(7'h00, 16'h0033);
    do_read("R10 unknown code", 7'h40, 16'h1111);
    do_write(7'h00, 16'h0070);
    do_write(7'h00, 16'h0000);
    do_read("R10 zero code", 7'h40, 16'h1111);

    // R11 one cycle latency and hold
    @(negedge clk);
    bus_addr = 7'h44; bus_re = 1'b1;
    #1;
    check("R11 before edge", bus_rdata, 16'h1111);
    @(negedge clk);
    bus_re = 1'b0;
    check("R11 after edge", bus_rdata, 16'h3333);
    bus_addr = 7'h40;
    repeat (2) @(negedge clk);
    check("R11 hold without strobe", bus_rdata, 16'h3333);

    // R1 reset in the middle of a program sequence
    do_write(7'h04, 16'h0040);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    do_read("R1 array erased", 7'h04, 16'hFFFF);
    do_write(7'h04, 16'h0034);
    do_read("R1 no pending program", 7'h04, 16'hFFFF);
    do_write(7'h00, 16'h0070);
    do_read("R1 status cleared", 7'h00, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule